// File: doc/BRIEF.md
# Enqueue Command Issue Unit

This unit sits between an execution pipeline and a device store port. It receives a 512-bit command block that has already been read from memory, a destination address and the value of the thread-identifier register. In the cycle the request is offered it checks three operand rules. If any rule is broken it reports a fault code and issues nothing. Otherwise it rewrites the low 32 bits of the command and sends a single 64-byte enqueue write on a valid/ready store port.

After the write is accepted, the unit waits for the device's one-cycle status pulse. The device either takes the command or asks for a retry, and the unit turns that answer into a zero-flag value. Each command finishes with a one-cycle `done` pulse that carries a six-bit flag vector and a two-bit fault code. Only one command can be outstanding. The request port stays closed from acceptance until the status returns.

Top module: `enq_issue_unit`

## Requirements
- R1: An issued command carries identifier-register bits 19:0 in bits 19:0 and zeros in bits 30:20. Bit 31 is 0 (user) whatever identifier-register bits 31:20 hold. Source bits 511:32 pass through unchanged, and `st_addr` equals the request address.
- R2: If identifier-register bit 31 (valid) is 0, the unit produces fault code 1 and issues no store.
- R3: If source bits 31:0 are not all zero, the unit produces fault code 2 and issues no store.
- R4: If address bits 5:0 are not all zero (not 64-byte aligned), the unit produces fault code 3 and issues no store.
- R5: When several rules fail, the lowest-numbered fault code is reported. Code 0 means no fault.
- R6: A status pulse with `st_status_retry`=0 (accepted) gives a zero flag of 0. A pulse with `st_status_retry`=1 gives a zero flag of 1. Both report fault code 0.
- R7: In `done_flags`, bit 3 is the zero flag and bits 5:4 and 2:0 are always 0. On a fault the whole vector is 0.
- R8: `req_ready` is low from the edge that accepts a valid command until the status pulse. `st_valid` stays high with stable `st_data` until `st_ready` is seen, and then drops on the next edge.
- R9: `done` rises for exactly one cycle per command. For a faulting request it follows the accepting edge. For an issued one it follows the status edge. A new request can be accepted in the cycle `done` is high.
- R10: A status pulse is ignored while no store is outstanding, and produces no `done`.
- R11: After reset, `req_ready`=1, `st_valid`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Unit idle, command taken when valid |
| req_src | input | 512 | Command block read from memory |
| req_addr | input | ADDR_W | Destination address |
| req_tid | input | 32 | Thread-identifier register (bit 31 valid, 19:0 identifier) |
| st_valid | output | 1 | Enqueue store request |
| st_ready | input | 1 | Store port accepts request |
| st_addr | output | ADDR_W | Store destination address |
| st_data | output | 512 | Formatted command |
| st_status_valid | input | 1 | One-cycle status pulse |
| st_status_retry | input | 1 | 1 = retry, 0 = accepted |
| done | output | 1 | One-cycle completion pulse |
| done_flags | output | 6 | Flag vector, bit 3 zero flag |
| done_fault | output | 2 | Fault code 0..3 |

## Verification
The case of interest is the `done` pulse of one command landing in the same cycle that the next command is accepted. The bench returns a status and, in the very cycle `done` is high, offers a new request. That request is sometimes faulting and sometimes clean. The bench then checks that the first completion shows the right zero flag, and that the second request is taken and completes on its own on the following cycle. Operands that break several rules at once exercise the fault priority.

// File: rtl/enq_pkg.sv
package enq_pkg;
    localparam int CMD_W      = 512;
    localparam int TID_W      = 32;
    localparam int ID_W       = 20;
    localparam int TID_VLD    = 31;
    localparam int PRIV_BIT   = 31;
    localparam int LANE_W     = 32;
    localparam int FLAG_W     = 6;
    localparam int ZF_BIT     = 3;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_TID   = 2'd1,
        FLT_SRC   = 2'd2,
        FLT_ALIGN = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } state_e;

    typedef struct packed {
        logic   zf;
        fault_e fault;
    } result_t;

    function automatic fault_e pick_fault(input logic tid_ok,
                                          input logic src_ok,
                                          input logic aligned);
        if (!tid_ok)       return FLT_TID;
        else if (!src_ok)  return FLT_SRC;
        else if (!aligned) return FLT_ALIGN;
        else               return FLT_NONE;
    endfunction

    function automatic logic [FLAG_W-1:0] flags_of(input logic zf);
        logic [FLAG_W-1:0] f;
        f = '0;
        f[ZF_BIT] = zf;
        return f;
    endfunction
endpackage

// File: rtl/enq_fault_chk.sv
module enq_fault_chk
    import enq_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    localparam int OFS_W = $clog2(LINE_BYTES)
) (
    input  logic              tid_valid,
    input  logic [LANE_W-1:0] src_low,
    input  logic [OFS_W-1:0]  addr_low,
    output fault_e            fault
);
    always_comb begin
        fault = pick_fault(tid_valid, src_low == '0, addr_low == '0);
    end

    always_comb begin
        assert_tid_first_R5: assert (tid_valid || fault == FLT_TID);
        assert_clean_R4: assert (!(tid_valid && src_low == '0 && addr_low == '0) || fault == FLT_NONE);
    end
endmodule

// File: rtl/enq_cmd_fmt.sv
module enq_cmd_fmt
    import enq_pkg::*;
(
    input  logic [CMD_W-1:0] src,
    input  logic [ID_W-1:0]  ident,
    output logic [CMD_W-1:0] cmd
);
    localparam int LANES = CMD_W / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_head
            logic [LANE_W-1:0] head;
            always_comb begin
                head = '0;
                head[ID_W-1:0] = ident;
                head[PRIV_BIT] = 1'b0;
            end
            assign cmd[LANE_W-1:0] = head;
        end else begin : g_body
            assign cmd[g*LANE_W +: LANE_W] = src[g*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/enq_issue_fsm.sv
module enq_issue_fsm
    import enq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  fault_e  fault,
    input  logic    st_ready,
    input  logic    st_status_valid,
    input  logic    st_status_retry,
    output logic    req_ready,
    output logic    st_valid,
    output logic    load_en,
    output logic    done,
    output result_t res
);
    state_e  state;
    logic    done_q;
    result_t res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            done_q <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (fault != FLT_NONE) begin
                            done_q      <= 1'b1;
                            res_q.zf    <= 1'b0;
                            res_q.fault <= fault;
                        end else begin
                            state <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: if (st_ready) state <= ST_WAIT;
                ST_WAIT: begin
                    if (st_status_valid) begin
                        done_q      <= 1'b1;
                        res_q.zf    <= st_status_retry;
                        res_q.fault <= FLT_NONE;
                        state       <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign st_valid  = (state == ST_ISSUE);
    assign load_en   = req_ready && req_valid && (fault == FLT_NONE);
    assign done      = done_q;
    assign res       = res_q;

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        st_valid && !st_ready |=> st_valid);
    assert_drop_R8: assert property (@(posedge clk) disable iff (rst)
        st_valid && st_ready |=> !st_valid && !req_ready);
    assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> !req_ready);
    assert_zf_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) && st_status_valid |=>
            done && res.zf == $past(st_status_retry) && res.fault == FLT_NONE);
    assert_noissue_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && fault != FLT_NONE |=>
            !st_valid && done && res.fault == $past(fault));
    assert_ignore_R10: assert property (@(posedge clk) disable iff (rst)
        req_ready && st_status_valid && !req_valid |=> !done);
endmodule

// File: rtl/enq_issue_unit.sv
module enq_issue_unit
    import enq_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int LINE_BYTES = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [CMD_W-1:0]    req_src,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [TID_W-1:0]    req_tid,
    output logic                st_valid,
    input  logic                st_ready,
    output logic [ADDR_W-1:0]   st_addr,
    output logic [CMD_W-1:0]    st_data,
    input  logic                st_status_valid,
    input  logic                st_status_retry,
    output logic                done,
    output logic [FLAG_W-1:0]   done_flags,
    output logic [1:0]          done_fault
);
    localparam int OFS_W = $clog2(LINE_BYTES);

    fault_e            fault;
    logic [CMD_W-1:0]  cmd_d;
    logic [CMD_W-1:0]  cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic              load_en;
    result_t           res;

    enq_fault_chk #(.LINE_BYTES(LINE_BYTES)) chk_i (
        .tid_valid (req_tid[TID_VLD]),
        .src_low   (req_src[LANE_W-1:0]),
        .addr_low  (req_addr[OFS_W-1:0]),
        .fault     (fault)
    );

    enq_cmd_fmt fmt_i (
        .src   (req_src),
        .ident (req_tid[ID_W-1:0]),
        .cmd   (cmd_d)
    );

    enq_issue_fsm fsm_i (
        .clk             (clk),
        .rst             (rst),
        .req_valid       (req_valid),
        .fault           (fault),
        .st_ready        (st_ready),
        .st_status_valid (st_status_valid),
        .st_status_retry (st_status_retry),
        .req_ready       (req_ready),
        .st_valid        (st_valid),
        .load_en         (load_en),
        .done            (done),
        .res             (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            addr_q <= '0;
        end else if (load_en) begin
            cmd_q  <= cmd_d;
            addr_q <= req_addr;
        end
    end

    assign st_data    = cmd_q;
    assign st_addr    = addr_q;
    assign done_flags = done ? flags_of(res.zf) : '0;
    assign done_fault = done ? res.fault : FLT_NONE;

    assert_low_word_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && fault == FLT_NONE |=>
            st_valid && st_data[LANE_W-1:0] == ($past(req_tid) & 32'h000F_FFFF)
            && st_data[CMD_W-1:LANE_W] == $past(req_src[CMD_W-1:LANE_W]));
    assert_stable_R8: assert property (@(posedge clk) disable iff (rst)
        st_valid && !st_ready |=> $stable(st_data) && $stable(st_addr));
    assert_flags_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> $countones(done_flags) <= 1 && done_flags[ZF_BIT] == (done_flags != '0));
endmodule

// File: tb/enq_issue_unit_tb_top.sv
module enq_issue_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 48;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [511:0]      req_src = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_tid = '0;
    logic              st_valid;
    logic              st_ready = 1'b0;
    logic [ADDR_W-1:0] st_addr;
    logic [511:0]      st_data;
    logic              st_status_valid = 1'b0;
    logic              st_status_retry = 1'b0;
    logic              done;
    logic [5:0]        done_flags;
    logic [1:0]        done_fault;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    enq_issue_unit #(.ADDR_W(ADDR_W), .LINE_BYTES(64)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_src(req_src), .req_addr(req_addr), .req_tid(req_tid),
        .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data),
        .st_status_valid(st_status_valid), .st_status_retry(st_status_retry),
        .done(done), .done_flags(done_flags), .done_fault(done_fault)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_fault(input logic [511:0] s,
                                             input logic [ADDR_W-1:0] a,
                                             input logic [31:0] t);
        if (!t[31])            return 2'd1;
        if (s[31:0] != 32'd0)  return 2'd2;
        if (a[5:0] != 6'd0)    return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic [511:0] exp_cmd(input logic [511:0] s, input logic [31:0] t);
        return {s[511:32], 1'b0, 11'd0, t[19:0]};
    endfunction

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic string fault_req(input logic [1:0] f);
        if (f == 2'd1) return "R2";
        if (f == 2'd2) return "R3";
        return "R4";
    endfunction

    // head=1: drive in the current negedge; tail=0: leave the done cycle open for overlap
    task automatic send(input logic [511:0] s, input logic [ADDR_W-1:0] a,
                        input logic [31:0] t, input int stall, input int lat,
                        input bit retry, input bit head, input bit tail);
        logic [1:0]   ef;
        logic [511:0] ec;
        ef = exp_fault(s, a, t);
        ec = exp_cmd(s, t);
        if (!head) @(negedge clk);
        chk(req_ready == 1'b1, "R9", "ready before offer", 512'(req_ready), 512'd1);
        req_valid = 1'b1; req_src = s; req_addr = a; req_tid = t;
        @(negedge clk);
        req_valid = 1'b0;
        if (ef != 2'd0) begin
            chk(done == 1'b1, "R9", "fault done pulse", 512'(done), 512'd1);
            chk(done_fault == ef, fault_req(ef), "fault code", 512'(done_fault), 512'(ef));
            chk(done_flags == 6'd0, "R7", "flags on fault", 512'(done_flags), 512'd0);
            chk(st_valid == 1'b0, fault_req(ef), "no store on fault", 512'(st_valid), 512'd0);
            if (tail) begin
                @(negedge clk);
                chk(done == 1'b0, "R9", "done one cycle", 512'(done), 512'd0);
            end
            return;
        end
        chk(st_valid == 1'b1, "R8", "store issued", 512'(st_valid), 512'd1);
        chk(st_data == ec, "R1", "command data", st_data, ec);
        chk(st_addr == a, "R1", "store address", 512'(st_addr), 512'(a));
        chk(req_ready == 1'b0, "R8", "busy after accept", 512'(req_ready), 512'd0);
        chk(done == 1'b0, "R9", "no early done", 512'(done), 512'd0);
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            chk(st_valid == 1'b1 && st_data == ec, "R8", "held under stall", st_data, ec);
        end
        st_ready = 1'b1;
        @(negedge clk);
        st_ready = 1'b0;
        chk(st_valid == 1'b0, "R8", "store drops after ready", 512'(st_valid), 512'd0);
        for (int k = 0; k < lat; k++) begin
            chk(done == 1'b0 && req_ready == 1'b0, "R8", "busy waiting status",
                512'({done, req_ready}), 512'd0);
            @(negedge clk);
        end
        st_status_valid = 1'b1; st_status_retry = retry;
        @(negedge clk);
        st_status_valid = 1'b0; st_status_retry = 1'b0;
        chk(done == 1'b1, "R9", "done after status", 512'(done), 512'd1);
        chk(done_flags == (retry ? 6'b001000 : 6'b000000), "R6", "zero flag",
            512'(done_flags), 512'(retry ? 6'b001000 : 6'b000000));
        chk(done_fault == 2'd0, "R6", "no fault on status", 512'(done_fault), 512'd0);
        chk(req_ready == 1'b1, "R8", "ready with done", 512'(req_ready), 512'd1);
        if (tail) begin
            @(negedge clk);
            chk(done == 1'b0, "R9", "done one cycle", 512'(done), 512'd0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [511:0]      s;
        logic [ADDR_W-1:0] a;
        logic [31:0]       t;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1 && st_valid == 1'b0 && done == 1'b0, "R11", "reset state",
            512'({req_ready, st_valid, done}), 512'b100);

        // R10: stray status while idle
        st_status_valid = 1'b1; st_status_retry = 1'b1;
        @(negedge clk);
        st_status_valid = 1'b0; st_status_retry = 1'b0;
        chk(done == 1'b0, "R10", "stray status ignored", 512'(done), 512'd0);
        chk(req_ready == 1'b1 && st_valid == 1'b0, "R10", "state unchanged",
            512'({req_ready, st_valid}), 512'b10);

        // directed: accepted and retry, upper identifier bits set to test R1 forcing
        s = rnd512(); s[31:0] = '0;
        send(s, 48'h1234_5678_9A40, 32'hFFFF_FFFF, 2, 1, 1'b0, 1'b0, 1'b1);
        send(s, 48'h0000_0000_0000, 32'h8000_0001, 0, 0, 1'b1, 1'b0, 1'b1);

        // R5: priority with several violations
        send(s | 512'h1, 48'h3F, 32'h7FFF_FFFF, 0, 0, 1'b0, 1'b0, 1'b1);
        send(s | 512'h1, 48'h3F, 32'h8000_0000, 0, 0, 1'b0, 1'b0, 1'b1);
        send(s, 48'h01, 32'h8000_0000, 0, 0, 1'b0, 1'b0, 1'b1);

        // R9: new request accepted in the done cycle (fault, then clean)
        send(s, 48'h40, 32'h800A_BCDE, 1, 2, 1'b1, 1'b0, 1'b0);
        send(s, 48'h80, 32'h0000_0000, 0, 0, 1'b0, 1'b1, 1'b0);
        send(s, 48'hC0, 32'h8001_2345, 0, 1, 1'b0, 1'b1, 1'b1);

        for (int i = 0; i < 60; i++) begin
            int kind;
            kind = int'($urandom % 8);
            s = rnd512(); s[31:0] = '0;
            a = {$urandom, $urandom};
            a[5:0] = '0;
            t = $urandom; t[31] = 1'b1;
            if (kind == 0) t[31] = 1'b0;
            if (kind == 1) s[($urandom % 32)] = 1'b1;
            if (kind == 2) a[($urandom % 6)] = 1'b1;
            send(s, a, t, int'($urandom % 4), int'($urandom % 4), 1'($urandom),
                 1'b0, 1'b1);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule